// File: doc/BRIEF.md
# Serial Port Control and Interrupt Logic

This block holds the control bits and the status flags of an asynchronous serial port and turns them into three interrupt request lines. A processor reaches it over a byte-wide register bus with one read strobe and one write strobe. The shift engines, baud generator and data registers are outside the block. They report events to it on single-cycle strobe inputs, and the block gives them the start gates for the transmitter and the receiver.

Status flags are cleared in two steps. Software first reads the status register while the flag is 1, then writes 0 to that bit. A flag that was not armed by such a read ignores a write of 0, and a write of 1 never changes a flag. The transmit-empty flag is pinned at 1 whenever the transmitter is disabled. Disabling the receiver leaves the receive flags untouched.

There is no data stream through the block, so no port uses valid/ready handshaking. Every pin is a plain level or a one-cycle strobe and has no back-pressure. Register reads return data combinationally in the cycle of the read strobe.

Top module: `sercomm_ctrl`

## Requirements
- R1: Address 0 is the control register. Bit 7 is transmit-interrupt enable, bit 6 is receive-interrupt enable, bit 5 is transmit enable and bit 4 is receive enable. All four reset to 0, can be written and read back, and bits 3..0 always read as 0.
- R2: Address 1 is the status register. Bit 7 is transmit-empty, bit 6 is receive-full, bit 5 is overrun, bit 4 is framing error and bit 3 is parity error, and bits 2..0 read as 0. After reset it reads 0x80.
- R3: A status write with a flag's bit at 0 clears that flag only if a status read since the flag was last set returned it as 1. A write of 0 to a flag that was not armed this way has no effect, and a write of 1 to a flag has no effect.
- R4: irq_tx is a registered level equal to transmit-interrupt enable AND transmit-empty, taken one cycle earlier.
- R5: irq_rx equals receive-interrupt enable AND receive-full, and irq_err equals receive-interrupt enable AND (overrun OR framing OR parity). Both are registered with one cycle of delay, so clearing the enable or the flag drops the line one cycle later.
- R6: While transmit enable is 0, transmit-empty is held at 1 from the next cycle onward, and clear attempts on it have no effect.
- R7: An effective clear of transmit-empty while transmit enable is 1 gives a one-cycle pulse on tx_go in the cycle after the write. A tx_done strobe sets transmit-empty.
- R8: While receive enable is 0, rx_done strobes are ignored and the receive flags keep their values.
- R9: rx_go is high only when rx_start is high and receive enable is 1.
- R10: When receive enable is 1 and rx_done arrives, the result depends on receive-full. If receive-full is 1, only overrun is set. If receive-full is 0, rx_ferr sets framing error, rx_perr sets parity error, and receive-full is set only when neither error is present.
- R11: If a flag is set by an event in the same cycle as an armed clear write, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tx_done | input | 1 | Transmit engine took the data byte |
| rx_start | input | 1 | Start bit detected on the line |
| rx_done | input | 1 | Receive engine finished a frame |
| rx_ferr | input | 1 | Frame had a bad stop bit (valid with rx_done) |
| rx_perr | input | 1 | Frame had a parity mismatch (valid with rx_done) |
| tx_go | output | 1 | Start pulse to the transmit engine |
| rx_go | output | 1 | Gated start to the receive engine |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Receive error interrupt request |

## Verification
The properties assume that at most one bus strobe is active in any cycle, so a status write never coincides with a status read. They also assume that reset is asserted from time zero until after the first clock edge. The stimulus drives every strobe for exactly one cycle, issues bus operations one at a time from tasks, and drives the engine strobes alongside a bus write only in the deliberate set-versus-clear collision case.

// File: rtl/sercomm_pkg.sv
package sercomm_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_FLAGS = 5;
  localparam int CTL_ADDR  = 0;
  localparam int STAT_ADDR = 1;

  // Flag index i sits at status bit (BYTE_W-1-i).
  localparam int F_TXE = 0;
  localparam int F_RXF = 1;
  localparam int F_OVR = 2;
  localparam int F_FRM = 3;
  localparam int F_PAR = 4;

  typedef struct packed {
    logic tx_irq_en;
    logic rx_irq_en;
    logic tx_en;
    logic rx_en;
  } ctl_t;

  function automatic int stat_bit(input int idx);
    return BYTE_W - 1 - idx;
  endfunction
endpackage

// File: rtl/sercomm_ctl_reg.sv
module sercomm_ctl_reg
  import sercomm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wbits,
  output ctl_t       ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctl <= '0;
    else if (wr_en) ctl <= ctl_t'(wbits);
  end
endmodule

// File: rtl/sercomm_flag.sv
module sercomm_flag #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic pin_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, arm_q, flag_d, arm_d;

  always_comb begin
    flag_d = flag_q;
    if (pin_i || set_i)              flag_d = 1'b1;
    else if (clr_i && arm_q && flag_q) flag_d = 1'b0;
    // An armed read is consumed by any clear attempt on this bit.
    arm_d = flag_d && !clr_i && (arm_q || (rd_i && flag_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= RESET_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sercomm_irq.sv
module sercomm_irq
  import sercomm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctl_t               ctl,
  input  logic [N_FLAGS-1:0] flags,
  output logic               irq_tx,
  output logic               irq_rx,
  output logic               irq_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_tx  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_tx  <= ctl.tx_irq_en & flags[F_TXE];
      irq_rx  <= ctl.rx_irq_en & flags[F_RXF];
      irq_err <= ctl.rx_irq_en & (flags[F_OVR] | flags[F_FRM] | flags[F_PAR]);
    end
  end
endmodule

// File: rtl/sercomm_ctrl.sv
module sercomm_ctrl
  import sercomm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              tx_done,
  input  logic              rx_start,
  input  logic              rx_done,
  input  logic              rx_ferr,
  input  logic              rx_perr,
  output logic              tx_go,
  output logic              rx_go,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  localparam int CTL_W = $bits(ctl_t);

  logic sel_ctl, sel_stat, stat_rd, stat_wr;
  ctl_t ctl_q;
  logic [N_FLAGS-1:0] flags, flag_set, flag_pin;
  logic [BYTE_W-1:0]  stat_byte;
  logic rx_evt, txe_d1;
  logic unused_wbits;

  assign sel_ctl  = (reg_addr == ADDR_W'(CTL_ADDR));
  assign sel_stat = (reg_addr == ADDR_W'(STAT_ADDR));
  assign stat_rd  = reg_rd & sel_stat;
  assign stat_wr  = reg_wr & sel_stat;
  assign unused_wbits = ^reg_wdata[BYTE_W-N_FLAGS-1:0];

  sercomm_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr & sel_ctl),
    .wbits (reg_wdata[BYTE_W-1 -: CTL_W]),
    .ctl   (ctl_q)
  );

  // Event sources for each flag.
  assign rx_evt = rx_done & ctl_q.rx_en;
  always_comb begin
    flag_set = '0;
    flag_pin = '0;
    flag_set[F_TXE] = tx_done;
    flag_pin[F_TXE] = ~ctl_q.tx_en;
    flag_set[F_OVR] = rx_evt &  flags[F_RXF];
    flag_set[F_RXF] = rx_evt & ~flags[F_RXF] & ~rx_ferr & ~rx_perr;
    flag_set[F_FRM] = rx_evt & ~flags[F_RXF] &  rx_ferr;
    flag_set[F_PAR] = rx_evt & ~flags[F_RXF] &  rx_perr;
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    sercomm_flag #(.RESET_VAL(i == F_TXE)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[i]),
      .pin_i  (flag_pin[i]),
      .rd_i   (stat_rd),
      .clr_i  (stat_wr & ~reg_wdata[stat_bit(i)]),
      .flag_o (flags[i])
    );
  end

  always_comb begin
    stat_byte = '0;
    for (int i = 0; i < N_FLAGS; i++) stat_byte[stat_bit(i)] = flags[i];
  end

  always_comb begin
    if (sel_ctl)       reg_rdata = {ctl_q, {(BYTE_W-CTL_W){1'b0}}};
    else if (sel_stat) reg_rdata = stat_byte;
    else               reg_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) txe_d1 <= 1'b1;
    else        txe_d1 <= flags[F_TXE];
  end

  assign tx_go = txe_d1 & ~flags[F_TXE] & ctl_q.tx_en;
  assign rx_go = rx_start & ctl_q.rx_en;

  sercomm_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl_q),
    .flags   (flags),
    .irq_tx  (irq_tx),
    .irq_rx  (irq_rx),
    .irq_err (irq_err)
  );
endmodule

// File: rtl/sercomm_ctrl_chk.sv
module sercomm_ctrl_chk
  import sercomm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [BYTE_W-1:0]  reg_wdata,
  input ctl_t               ctl,
  input logic [N_FLAGS-1:0] flags,
  input logic               tx_go,
  input logic               irq_tx,
  input logic               irq_rx,
  input logic               irq_err
);
  logic stat_wr;
  assign stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

  p_txirq_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.tx_irq_en && flags[F_TXE]) |=> irq_tx);
  p_txirq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.tx_irq_en |=> !irq_tx);
  p_rxirq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.rx_irq_en |=> (!irq_rx && !irq_err));
  p_txe_pinned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.tx_en |=> flags[F_TXE]);
  p_go_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> $past(stat_wr && !reg_wdata[stat_bit(F_TXE)] && ctl.tx_en));
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.rx_en && !stat_wr) |=> $stable(flags[N_FLAGS-1:F_RXF]));
  p_rxf_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_RXF]) |-> $past(stat_wr && !reg_wdata[stat_bit(F_RXF)]));
endmodule

bind sercomm_ctrl sercomm_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .ctl       (ctl_q),
  .flags     (flags),
  .tx_go     (tx_go),
  .irq_tx    (irq_tx),
  .irq_rx    (irq_rx),
  .irq_err   (irq_err)
);

// File: tb/sercomm_ctrl_test.sv
`timescale 1ns/1ps
module sercomm_ctrl_test;
  localparam int AW = 2;
  localparam int NV = 14;
  // Vector: op[18:17] (0 write, 1 read-check), addr[16], data[15:8], expected[7:0]
  localparam logic [18:0] VEC [NV] = '{
    {2'd1, 1'b0, 8'h00, 8'h00},  // R1 control resets to 0
    {2'd0, 1'b0, 8'h20, 8'h00},  // enable transmitter
    {2'd0, 1'b1, 8'h00, 8'h00},  // R3 unarmed clear
    {2'd1, 1'b1, 8'h00, 8'h80},  // R2/R3 still 0x80, arms
    {2'd0, 1'b1, 8'hFF, 8'h00},  // R3 write of ones
    {2'd1, 1'b1, 8'h00, 8'h80},  // R3 unchanged
    {2'd0, 1'b1, 8'h7F, 8'h00},  // armed clear of transmit-empty
    {2'd1, 1'b1, 8'h00, 8'h00},  // R3 cleared
    {2'd0, 1'b1, 8'h00, 8'h00},  // no armed flags
    {2'd0, 1'b0, 8'hF0, 8'h00},
    {2'd1, 1'b0, 8'h00, 8'hF0},  // R1 readback
    {2'd0, 1'b0, 8'h0F, 8'h00},
    {2'd1, 1'b0, 8'h00, 8'h00},  // R1 low bits read 0
    {2'd1, 1'b1, 8'h00, 8'h80}   // R6 TE=0 pins empty
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_rd = 0, reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic tx_done = 0, rx_start = 0, rx_done = 0, rx_ferr = 0, rx_perr = 0;
  logic tx_go, rx_go, irq_tx, irq_rx, irq_err;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rd_val;

  always #2.5 clk = ~clk;

  sercomm_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_done(tx_done), .rx_start(rx_start), .rx_done(rx_done),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr), .tx_go(tx_go), .rx_go(rx_go),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    reg_rd = 1; reg_addr = AW'(a);
    #1 d = reg_rdata;
    tick();
    reg_rd = 0;
  endtask

  task automatic rx_frame(input logic fe, input logic pe);
    rx_done = 1; rx_ferr = fe; rx_perr = pe;
    tick();
    rx_done = 0; rx_ferr = 0; rx_perr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk({5'd0, irq_tx, irq_rx, irq_err}, 8'h00, "R4 R5 reset irq");
    chk({7'd0, tx_go}, 8'h00, "R7 reset tx_go");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18:17] == 2'd0) bus_write(int'(VEC[i][16]), VEC[i][15:8]);
      else begin
        bus_read(int'(VEC[i][16]), rd_val);
        chk(rd_val, VEC[i][7:0], $sformatf("R1 R2 R3 R6 vector %0d", i));
      end
    end

    // R4 / R7 transmit path
    bus_write(0, 8'hA0);
    tick();
    chk({7'd0, irq_tx}, 8'h01, "R4 irq_tx rises");
    bus_read(1, rd_val);
    bus_write(1, 8'h7F);
    chk({7'd0, tx_go}, 8'h01, "R7 tx_go pulse");
    chk({7'd0, irq_tx}, 8'h01, "R4 irq_tx one-cycle lag");
    tick();
    chk({7'd0, tx_go}, 8'h00, "R7 tx_go single cycle");
    chk({7'd0, irq_tx}, 8'h00, "R4 irq_tx falls");
    tx_done = 1; tick(); tx_done = 0;
    tick();
    chk({7'd0, irq_tx}, 8'h01, "R7 tx_done sets empty");

    // R6 disabling transmitter pins empty
    bus_read(1, rd_val);
    bus_write(1, 8'h7F);
    bus_write(0, 8'h80);
    tick();
    bus_read(1, rd_val);
    chk(rd_val, 8'h80, "R6 empty pinned");
    bus_write(1, 8'h7F);
    tick();
    bus_read(1, rd_val);
    chk(rd_val, 8'h80, "R6 clear ignored");

    // R9 receiver start gate
    bus_write(0, 8'h00);
    rx_start = 1; #1 chk({7'd0, rx_go}, 8'h00, "R9 gated off"); rx_start = 0;
    bus_write(0, 8'h10);
    rx_start = 1; #1 chk({7'd0, rx_go}, 8'h01, "R9 gated on"); rx_start = 0;

    // R10 / R5 receive flags
    bus_write(0, 8'h50);
    rx_frame(0, 0);
    bus_read(1, rd_val);
    chk(rd_val, 8'hC0, "R10 receive-full set");
    chk({7'd0, irq_rx}, 8'h01, "R5 irq_rx");
    rx_frame(0, 0);
    tick();
    chk({7'd0, irq_err}, 8'h01, "R5 irq_err on overrun");
    rx_frame(1, 0);
    bus_read(1, rd_val);
    chk(rd_val, 8'hE0, "R10 only overrun while full");

    // R8 receiver disabled
    bus_write(0, 8'h40);
    rx_frame(0, 1);
    bus_read(1, rd_val);
    chk(rd_val, 8'hE0, "R8 flags retained");
    chk({7'd0, irq_rx}, 8'h01, "R8 irq_rx retained");

    // R3 / R5 clearing
    bus_write(1, 8'hBF);
    tick();
    chk({7'd0, irq_rx}, 8'h00, "R5 irq_rx falls");
    bus_read(1, rd_val);
    chk(rd_val, 8'hA0, "R3 receive-full cleared");
    bus_write(1, 8'hDF);
    tick();
    chk({7'd0, irq_err}, 8'h00, "R5 irq_err falls");
    bus_write(0, 8'h50);
    rx_frame(0, 0);
    bus_write(1, 8'hBF);
    bus_read(1, rd_val);
    chk(rd_val, 8'hC0, "R3 unarmed clear ignored");
    bus_write(1, 8'hBF);
    bus_read(1, rd_val);
    chk(rd_val, 8'h80, "R3 armed clear");

    // R10 error flags
    rx_frame(1, 1);
    tick();
    chk({7'd0, irq_err}, 8'h01, "R10 errors raise irq_err");
    bus_read(1, rd_val);
    chk(rd_val, 8'h98, "R10 framing and parity");

    // R11 set wins over clear
    reg_wr = 1; reg_addr = AW'(1); reg_wdata = 8'hE7;
    rx_done = 1; rx_ferr = 1;
    tick();
    reg_wr = 0; reg_wdata = '0; rx_done = 0; rx_ferr = 0;
    bus_read(1, rd_val);
    chk(rd_val, 8'h90, "R11 set beats clear");

    // R5 enable withdraws request
    bus_write(0, 8'h10);
    tick();
    chk({6'd0, irq_rx, irq_err}, 8'h00, "R5 enable cleared");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule